// File: doc/BRIEF.md
# Queued Audio Sample Fetcher with Rate Dividers

This block moves audio samples from system memory to a sample output. Software writes a start address and then a byte length into a small register window. The length write turns the address/length pair into a transfer request. Up to two requests are held: the one being fetched and one waiting behind it. While fetching is enabled, the block reads 32-bit words from memory through a simple request/response port. It stages the words in a small prefetch buffer.

A programmable sample timer, counted in video-clock cycles, emits one stereo sample per period. Each period takes one word out of the prefetch buffer. When the buffer is empty, the sample is zero. A second divider makes a serial bit clock with a programmable half-period. Software reads a status word that shows whether the block is busy and whether both request slots are taken. An interrupt is raised when a slot frees up, and any write to the status offset clears it.

Top module: `audio_dma_engine`

## Requirements
- R1: After reset, the status word reads 0, and irq, mem_req, sample_strobe, sample_out and bit_clk are all 0.
- R2: The start address written at offset 0x00 is stored with its three low bits cleared. A transfer requests consecutive 32-bit words starting at that address, 4 bytes apart.
- R3: A length written at offset 0x04 ignores its three low bits and every bit at or above LEN_W. A length of N bytes produces N/4 word requests.
- R4: A length write queues the staged address together with that length. At most two requests are held, and a length write made while both are held is dropped. Requests are fetched in the order they were written.
- R5: In the status word at offset 0x0C, bit 31 and bit 0 both read 1 while two requests are held, and bit 30 reads 1 while at least one request is held.
- R6: irq goes to 1 on the cycle after the both-held condition ends. Any write to offset 0x0C clears irq.
- R7: A request with zero length is accepted and retires on the next cycle without issuing any memory request.
- R8: Bit 0 of the control word at offset 0x08 enables the block. While it is 0, no memory request and no sample strobe is produced.
- R9: While enabled, sample_strobe pulses once every DP+1 cycles, where DP is the value at offset 0x10. Each pulse presents the next fetched word on sample_out, in fetch order.
- R10: A sample strobe that finds the prefetch buffer empty presents zero on sample_out.
- R11: With a bit-clock value H at offset 0x14 that is not 0, bit_clk is a square wave that is high for H+1 cycles and low for H+1 cycles. With H = 0, bit_clk stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response word |
| sample_out | output | 32 | Current stereo sample |
| sample_strobe | output | 1 | One-cycle pulse when sample_out updates |
| bit_clk | output | 1 | Divided serial bit clock |
| irq | output | 1 | Queue-space interrupt |

## Verification
The bench builds the block with LEN_W = 15, the narrower length field. A length value with bit 15 set therefore shows that the bits above the field are truncated. FIFO_DEPTH stays at 4, so the first four-word transfer fills the prefetch buffer exactly. The second queued request must then wait for samples to drain. This shows the promotion and the interrupt while words are still buffered. A sample period of 10 cycles puts several strobes, including underrun strobes, inside a short window.

// File: rtl/aud_pkg.sv
package aud_pkg;
  localparam logic [4:0] OFS_ADDR = 5'h00;
  localparam logic [4:0] OFS_LEN  = 5'h04;
  localparam logic [4:0] OFS_CTRL = 5'h08;
  localparam logic [4:0] OFS_STAT = 5'h0C;
  localparam logic [4:0] OFS_DPER = 5'h10;
  localparam logic [4:0] OFS_HALF = 5'h14;

  localparam int STAT_FULL_HI = 31;
  localparam int STAT_BUSY    = 30;
  localparam int STAT_FULL_LO = 0;
endpackage

// File: rtl/aud_cmd_queue.sv
module aud_cmd_queue #(
  parameter int AW = 24,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [CW-1:0] push_cnt,
  input  logic          issue,
  input  logic          idle,
  output logic          act_valid,
  output logic          pend_valid,
  output logic [AW-1:0] act_addr,
  output logic [CW-1:0] act_cnt
);
  logic          act_v_q, act_v_n, pend_v_q, pend_v_n;
  logic [AW-1:0] act_a_q, act_a_n, pend_a_q, pend_a_n;
  logic [CW-1:0] act_c_q, act_c_n, pend_c_q, pend_c_n;
  logic          retire;

  assign retire = act_v_q && (act_c_q == '0) && idle;

  always_comb begin
    act_v_n  = act_v_q;  act_a_n  = act_a_q;  act_c_n  = act_c_q;
    pend_v_n = pend_v_q; pend_a_n = pend_a_q; pend_c_n = pend_c_q;
    if (retire) begin
      if (pend_v_q) begin
        act_a_n  = pend_a_q;
        act_c_n  = pend_c_q;
        pend_v_n = 1'b0;
      end else begin
        act_v_n = 1'b0;
      end
    end else if (issue) begin
      act_a_n = act_a_q + AW'(4);
      act_c_n = act_c_q - CW'(1);
    end
    if (push) begin
      if (!act_v_q || (retire && !pend_v_q)) begin
        act_v_n = 1'b1;
        act_a_n = push_addr;
        act_c_n = push_cnt;
      end else if (!pend_v_q) begin
        pend_v_n = 1'b1;
        pend_a_n = push_addr;
        pend_c_n = push_cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_v_q <= 1'b0; act_a_q <= '0; act_c_q <= '0;
      pend_v_q <= 1'b0; pend_a_q <= '0; pend_c_q <= '0;
    end else begin
      act_v_q <= act_v_n; act_a_q <= act_a_n; act_c_q <= act_c_n;
      pend_v_q <= pend_v_n; pend_a_q <= pend_a_n; pend_c_q <= pend_c_n;
    end
  end

  assign act_valid  = act_v_q;
  assign pend_valid = pend_v_q;
  assign act_addr   = act_a_q;
  assign act_cnt    = act_c_q;
endmodule

// File: rtl/aud_fifo.sv
module aud_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && ((cnt_q != CW'(DEPTH)) || do_pop);

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (do_push) wp_n = (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + PW'(1);
    if (do_pop)  rp_n = (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + PW'(1);
    if (do_push && !do_pop) cnt_n = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      wp_q <= wp_n; rp_q <= rp_n; cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign level = cnt_q;
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen #(
  parameter int DPER_W = 14,
  parameter int HP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DPER_W-1:0] dper,
  input  logic [HP_W-1:0]   half,
  output logic              tick,
  output logic              bit_clk
);
  logic [DPER_W-1:0] scnt_q, scnt_n;
  logic [HP_W-1:0]   hcnt_q, hcnt_n;
  logic              bclk_q, bclk_n;

  assign tick = en && (scnt_q == dper);

  always_comb begin
    if (!en || tick) scnt_n = '0;
    else             scnt_n = scnt_q + DPER_W'(1);

    hcnt_n = hcnt_q;
    bclk_n = bclk_q;
    if (half == '0) begin
      hcnt_n = '0;
      bclk_n = 1'b0;
    end else if (hcnt_q >= half) begin
      hcnt_n = '0;
      bclk_n = !bclk_q;
    end else begin
      hcnt_n = hcnt_q + HP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q <= '0; hcnt_q <= '0; bclk_q <= 1'b0;
    end else begin
      scnt_q <= scnt_n; hcnt_q <= hcnt_n; bclk_q <= bclk_n;
    end
  end

  assign bit_clk = bclk_q;
endmodule

// File: rtl/audio_dma_engine.sv
module audio_dma_engine #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 18,
  parameter int DPER_W     = 14,
  parameter int HP_W       = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic [31:0]       sample_out,
  output logic              sample_strobe,
  output logic              bit_clk,
  output logic              irq
);
  import aud_pkg::*;

  localparam int WC_W = LEN_W - 2;
  localparam int LV_W = $clog2(FIFO_DEPTH + 1);

  logic [ADDR_W-4:0] astage_q, astage_n;
  logic [DPER_W-1:0] dper_q, dper_n;
  logic [HP_W-1:0]   half_q, half_n;
  logic              en_q, en_n, irq_q, irq_n, full_d_q;
  logic              outst_q, outst_n, strobe_q;
  logic [31:0]       samp_q, samp_n;

  logic              push, act_v, pend_v, tick, fifo_empty;
  logic [ADDR_W-1:0] act_addr;
  logic [WC_W-1:0]   act_cnt, push_cnt;
  logic [31:0]       fifo_head;
  logic [LV_W-1:0]   fifo_level;

  assign push     = reg_we && (reg_addr == OFS_LEN);
  assign push_cnt = {reg_wdata[LEN_W-1:3], 1'b0};
  assign mem_req  = en_q && act_v && (act_cnt != '0) && !outst_q &&
                    (fifo_level < LV_W'(FIFO_DEPTH));
  assign mem_addr = act_addr;

  aud_cmd_queue #(.AW(ADDR_W), .CW(WC_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push),
    .push_addr({astage_q, 3'b000}), .push_cnt(push_cnt),
    .issue(mem_req), .idle(!outst_q),
    .act_valid(act_v), .pend_valid(pend_v),
    .act_addr(act_addr), .act_cnt(act_cnt)
  );

  aud_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(mem_rvalid), .wdata(mem_rdata),
    .pop(tick), .rdata(fifo_head), .empty(fifo_empty), .level(fifo_level)
  );

  aud_clkgen #(.DPER_W(DPER_W), .HP_W(HP_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .en(en_q), .dper(dper_q), .half(half_q),
    .tick(tick), .bit_clk(bit_clk)
  );

  always_comb begin
    astage_n = astage_q;
    dper_n   = dper_q;
    half_n   = half_q;
    en_n     = en_q;
    if (reg_we) begin
      case (reg_addr)
        OFS_ADDR: astage_n = reg_wdata[ADDR_W-1:3];
        OFS_CTRL: en_n     = reg_wdata[0];
        OFS_DPER: dper_n   = reg_wdata[DPER_W-1:0];
        OFS_HALF: half_n   = reg_wdata[HP_W-1:0];
        default: ;
      endcase
    end
    irq_n = irq_q;
    if (reg_we && (reg_addr == OFS_STAT)) irq_n = 1'b0;
    if (full_d_q && !pend_v) irq_n = 1'b1;
    outst_n = outst_q;
    if (mem_req)    outst_n = 1'b1;
    if (mem_rvalid) outst_n = 1'b0;
    samp_n = samp_q;
    if (tick) samp_n = fifo_empty ? 32'h0 : fifo_head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      astage_q <= '0; dper_q <= '0; half_q <= '0; en_q <= 1'b0;
      irq_q <= 1'b0; full_d_q <= 1'b0; outst_q <= 1'b0;
      samp_q <= '0; strobe_q <= 1'b0;
    end else begin
      astage_q <= astage_n; dper_q <= dper_n; half_q <= half_n; en_q <= en_n;
      irq_q <= irq_n; full_d_q <= pend_v; outst_q <= outst_n;
      samp_q <= samp_n; strobe_q <= tick;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: reg_rdata = {31'b0, en_q};
      OFS_STAT: begin
        reg_rdata[STAT_FULL_HI] = pend_v;
        reg_rdata[STAT_BUSY]    = act_v;
        reg_rdata[STAT_FULL_LO] = pend_v;
      end
      OFS_DPER: reg_rdata = 32'(dper_q);
      OFS_HALF: reg_rdata = 32'(half_q);
      default: ;
    endcase
  end

  assign sample_out    = samp_q;
  assign sample_strobe = strobe_q;
  assign irq           = irq_q;
endmodule

// File: rtl/aud_dma_checker.sv
module aud_dma_checker #(
  parameter int AW   = 24,
  parameter int HP_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            full,
  input logic            busy,
  input logic            irq,
  input logic            en,
  input logic            mem_req,
  input logic [AW-1:0]   mem_addr,
  input logic [HP_W-1:0] half,
  input logic            bit_clk
);
  assert_full_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> busy);

  assert_irq_after_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |=> irq);

  assert_quiet_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !mem_req);

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_one_in_flight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_bitclk_parked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (half == '0) |=> !bit_clk);
endmodule

bind audio_dma_engine aud_dma_checker #(.AW(ADDR_W), .HP_W(HP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .full(pend_v), .busy(act_v), .irq(irq),
  .en(en_q), .mem_req(mem_req), .mem_addr(mem_addr), .half(half_q),
  .bit_clk(bit_clk)
);

// File: tb/audio_dma_engine_test.sv
module audio_dma_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic [31:0]   sample_out;
  logic          sample_strobe;
  logic          bit_clk;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_dma_engine #(.LEN_W(15), .FIFO_DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .sample_out(sample_out), .sample_strobe(sample_strobe),
    .bit_clk(bit_clk), .irq(irq)
  );

  // memory model and observers, all at the falling edge
  logic        rsp_pend = 1'b0;
  logic [31:0] rsp_data = '0;
  int          cyc = 0;
  int          nreq = 0;
  int          nstb = 0;
  logic [31:0] req_addr [64];
  logic [31:0] stb_data [64];
  int          stb_cyc  [64];

  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_rvalid = rsp_pend;
    mem_rdata  = rsp_data;
    rsp_pend   = mem_req;
    rsp_data   = {8'hC3, mem_addr};
    if (mem_req && nreq < 64) begin
      req_addr[nreq] = 32'(mem_addr);
      nreq = nreq + 1;
    end
    if (sample_strobe && nstb < 64) begin
      stb_data[nstb] = sample_out;
      stb_cyc[nstb]  = cyc;
      nstb = nstb + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic clear_obs();
    @(posedge clk);
    nreq = 0;
    nstb = 0;
  endtask

  task automatic t_reset();
    logic [31:0] s;
    rd(5'h0C, s);
    check(s == 32'h0, "R1 status", s, 32'h0);
    check({irq, mem_req, sample_strobe, bit_clk} == 4'b0, "R1 outputs",
          32'({irq, mem_req, sample_strobe, bit_clk}), 32'h0);
    check(sample_out == 32'h0, "R1 sample", sample_out, 32'h0);
  endtask

  task automatic t_bitclk();
    int hi = 0;
    int lo = 0;
    int zeros = 0;
    wr(5'h14, 32'd3);
    for (int i = 0; i < 40 && bit_clk == 1'b0; i++) @(negedge clk);
    for (int i = 0; i < 40 && bit_clk == 1'b1; i++) begin hi++; @(negedge clk); end
    for (int i = 0; i < 40 && bit_clk == 1'b0; i++) begin lo++; @(negedge clk); end
    check(hi == 4, "R11 high phase", 32'(hi), 32'd4);
    check(lo == 4, "R11 low phase", 32'(lo), 32'd4);
    wr(5'h14, 32'd0);
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      if (bit_clk == 1'b0) zeros++;
      @(negedge clk);
    end
    check(zeros == 20, "R11 parked low", 32'(zeros), 32'd20);
  endtask

  task automatic t_queue();
    logic [31:0] s;
    logic [31:0] exp_a [6] = '{32'h1000, 32'h1004, 32'h1008, 32'h100C,
                               32'h2000, 32'h2004};
    int bad_a = 0;
    int bad_d = 0;
    clear_obs();
    wr(5'h00, 32'h0000_1003);
    wr(5'h04, 32'h10);
    rd(5'h0C, s);
    check(s == 32'h4000_0000, "R5 busy only", s, 32'h4000_0000);
    wr(5'h00, 32'h0000_2000);
    wr(5'h04, 32'h08);
    rd(5'h0C, s);
    check(s == 32'hC000_0001, "R5 full bits", s, 32'hC000_0001);
    wr(5'h00, 32'h0000_3000);
    wr(5'h04, 32'h08);
    check(nreq == 0, "R8 no fetch while off", 32'(nreq), 32'h0);
    check(irq == 1'b0, "R6 no irq yet", 32'(irq), 32'h0);
    wr(5'h10, 32'd9);
    wr(5'h08, 32'h1);
    repeat (150) @(negedge clk);
    check(nreq == 6, "R4 third write dropped", 32'(nreq), 32'd6);
    for (int i = 0; i < 6; i++) if (req_addr[i] != exp_a[i]) bad_a++;
    check(bad_a == 0, "R2 request addresses", req_addr[0], exp_a[0]);
    for (int i = 0; i < 6; i++) if (stb_data[i] != {8'hC3, exp_a[i][23:0]}) bad_d++;
    check(bad_d == 0, "R9 sample order", stb_data[0], {8'hC3, 24'h1000});
    check(stb_cyc[1] - stb_cyc[0] == 10, "R9 strobe interval",
          32'(stb_cyc[1] - stb_cyc[0]), 32'd10);
    check(nstb >= 8 && stb_data[6] == 32'h0 && stb_data[7] == 32'h0,
          "R10 underrun zero", stb_data[6], 32'h0);
    check(irq == 1'b1, "R6 irq after full drop", 32'(irq), 32'h1);
    wr(5'h0C, 32'h0);
    check(irq == 1'b0, "R6 irq cleared", 32'(irq), 32'h0);
    rd(5'h0C, s);
    check(s == 32'h0, "R5 idle status", s, 32'h0);
  endtask

  task automatic t_lenbits();
    clear_obs();
    wr(5'h00, 32'h0000_0408);
    wr(5'h04, 32'h0000_800F);
    repeat (40) @(negedge clk);
    check(nreq == 2, "R3 word count", 32'(nreq), 32'd2);
    check(req_addr[0] == 32'h408 && req_addr[1] == 32'h40C, "R3 addresses",
          req_addr[1], 32'h40C);
  endtask

  task automatic t_zero();
    logic [31:0] s;
    clear_obs();
    wr(5'h00, 32'h0000_5000);
    wr(5'h04, 32'h0);
    rd(5'h0C, s);
    check(s == 32'h4000_0000, "R7 zero length accepted", s, 32'h4000_0000);
    @(negedge clk);
    rd(5'h0C, s);
    check(s == 32'h0, "R7 zero length retired", s, 32'h0);
    repeat (10) @(negedge clk);
    check(nreq == 0, "R7 no request", 32'(nreq), 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] s;
    wr(5'h08, 32'h0);
    clear_obs();
    wr(5'h00, 32'h0000_6000);
    wr(5'h04, 32'h08);
    repeat (40) @(negedge clk);
    check(nreq == 0 && nstb == 0, "R8 disabled quiet", 32'(nreq + nstb), 32'h0);
    rd(5'h0C, s);
    check(s == 32'h4000_0000, "R8 entry held", s, 32'h4000_0000);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bitclk();
    t_queue();
    t_lenbits();
    t_zero();
    t_disable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule